// File: doc/BRIEF.md
# Bus-Attached Peripheral Command Unit

This block connects a simple single-cycle CPU register bus to one slow external device. It decodes its own window in the upper sixteenth of the address space and exposes three registers at fixed offsets from the window base: a status word, a data byte and a command word. Writing the command word starts one of four operations. An action operation forwards a device-specific code as a one-cycle strobe. A probe operation only records the command. A fetch operation brings one byte in from the device. A send operation pushes the held data byte out to the device.

Fetch and send operations use a request/acknowledge exchange that may last any number of cycles. During the exchange the unit reports itself busy and refuses further transfers. When the exchange finishes it flags the result as ready and, if enabled, raises an interrupt line. Incoming bytes carry an even-parity bit, and a mismatch is latched as an error until software clears it.

Top module: `mmio_io_unit`

## Requirements
- R1: An access with bus_addr[31:28] equal to 4'hF (BASE_ADDR default 32'hF000_0000) sets bus_hit high in the cycle after the access. An access outside that window leaves bus_hit low, returns 0 on bus_rdata and changes no state.
- R2: The status word at offset 0x0 reads as bit0 busy, bit1 ready, bit2 error, bit3 overrun, with all other bits 0. Reading it has no side effect. Read data of any access appears on bus_rdata in the cycle after the access.
- R3: Writing the command word at offset 0x8 with bits[1:0]=2'b10 (fetch) while idle raises dev_req with dev_dir=0 and sets busy on the next edge. On the edge where dev_ack is sampled high, the unit captures dev_rdata, and a later read of offset 0x4 returns that byte in bits[7:0].
- R4: Writing bits[1:0]=2'b11 (send) while idle raises dev_req with dev_dir=1. dev_wdata carries the byte last written to offset 0x4, and dev_wpar is the XOR of its eight bits (even parity).
- R5: Writing bits[1:0]=2'b00 (action) pulses dev_act_stb for exactly one cycle on the next edge, with dev_act_code equal to bits[7:4]. The command word reads back as the last accepted write: bits[1:0] command, bit2 interrupt enable, bits[7:4] action code.
- R6: A fetch or send command written while busy is ignored: the ongoing request, its direction and the command word readback do not change, and status bit3 (overrun) becomes set. Overrun stays set until a status write with bit3=1.
- R7: A fetched byte whose parity bit differs from the XOR of its data bits sets status bit2 (error). A status write with bit2=1 clears it, and bits written as 0 leave it unchanged.
- R8: Completion of a fetch or send sets ready on the acknowledge edge. If the interrupt enable (command word bit2) is 1, irq rises on the same edge. Reading offset 0x4 clears ready and irq. With the enable at 0, irq stays low.
- R9: Accesses inside the window at offsets other than 0x0, 0x4 and 0x8 return 0 and are ignored on write.
- R10: After reset, status reads 0, the command word reads 0, and dev_req, dev_act_stb and irq are low.
- R11: dev_req stays high until dev_ack is sampled high and drops on that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 32 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_hit | output | 1 | Registered: last access fell inside the window |
| irq | output | 1 | Completion interrupt |
| dev_req | output | 1 | Transfer request to device |
| dev_dir | output | 1 | 1 = send to device, 0 = fetch from device |
| dev_wdata | output | 8 | Byte sent to device |
| dev_wpar | output | 1 | Even parity of dev_wdata |
| dev_ack | input | 1 | Device acknowledge |
| dev_rdata | input | 8 | Byte from device, valid with dev_ack |
| dev_rpar | input | 1 | Parity bit from device |
| dev_act_stb | output | 1 | One-cycle action strobe |
| dev_act_code | output | 4 | Action code for the strobe |

## Verification
Every bus access takes effect on the edge that samples it. bus_rdata and bus_hit are due one cycle later, and busy, dev_req and dev_act_stb also change on that edge. Ready, error, irq and the drop of dev_req are due on the very edge where dev_ack is sampled. The bench drives every input just after a falling edge and reads every output at the next falling edge, so each check falls exactly one half period after the edge that should produce its value. The device acknowledge is held off for several cycles so that busy, the held request and the overrun refusal can be observed mid-transfer.

// File: rtl/mmio_pkg.sv
package mmio_pkg;
  typedef enum logic [1:0] {
    CMD_ACTION = 2'b00,
    CMD_PROBE  = 2'b01,
    CMD_FETCH  = 2'b10,
    CMD_SEND   = 2'b11
  } cmd_e;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_STAT,
    SEL_DATA,
    SEL_CTRL
  } sel_e;

  localparam int ST_BUSY  = 0;
  localparam int ST_READY = 1;
  localparam int ST_ERR   = 2;
  localparam int ST_OVR   = 3;

  localparam int CW_IE       = 2;
  localparam int CW_ACT_LSB  = 4;
endpackage

// File: rtl/mmio_decode.sv
module mmio_decode
  import mmio_pkg::*;
#(
  parameter int          AW       = 32,
  parameter int          WIN_BITS = 28,
  parameter logic [AW-1:0] BASE   = 32'hF000_0000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sel_i,
  input  logic [AW-1:0] addr_i,
  output sel_e          reg_o,
  output logic          hit_o
);
  localparam logic [WIN_BITS-1:0] OFF_STAT = WIN_BITS'(0);
  localparam logic [WIN_BITS-1:0] OFF_DATA = WIN_BITS'(4);
  localparam logic [WIN_BITS-1:0] OFF_CTRL = WIN_BITS'(8);

  logic                in_win;
  logic [WIN_BITS-1:0] off;

  assign in_win = (addr_i[AW-1:WIN_BITS] == BASE[AW-1:WIN_BITS]);
  assign off    = addr_i[WIN_BITS-1:0];

  always_comb begin
    reg_o = SEL_NONE;
    if (sel_i && in_win) begin
      unique case (off)
        OFF_STAT: reg_o = SEL_STAT;
        OFF_DATA: reg_o = SEL_DATA;
        OFF_CTRL: reg_o = SEL_CTRL;
        default:  reg_o = SEL_NONE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) hit_o <= 1'b0;
    else     hit_o <= sel_i && in_win;
  end

  p_no_hit_outside_r1: assert property (@(posedge clk) disable iff (rst)
    (sel_i && (addr_i[AW-1:WIN_BITS] != BASE[AW-1:WIN_BITS])) |=> !hit_o);
endmodule

// File: rtl/mmio_dev_fsm.sv
module mmio_dev_fsm #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic          start_dir_i,
  input  logic [DW-1:0] tx_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          done_dir_o,
  output logic [DW-1:0] rx_o,
  output logic          perr_o,
  output logic          dev_req,
  output logic          dev_dir,
  output logic [DW-1:0] dev_wdata,
  output logic          dev_wpar,
  input  logic          dev_ack,
  input  logic [DW-1:0] dev_rdata,
  input  logic          dev_rpar
);
  typedef enum logic {S_IDLE, S_WAIT} st_e;
  st_e st_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= S_IDLE;
      dev_req   <= 1'b0;
      dev_dir   <= 1'b0;
      dev_wdata <= '0;
      dev_wpar  <= 1'b0;
    end else begin
      unique case (st_q)
        S_IDLE: if (start_i) begin
          st_q      <= S_WAIT;
          dev_req   <= 1'b1;
          dev_dir   <= start_dir_i;
          dev_wdata <= tx_i;
          dev_wpar  <= ^tx_i;
        end
        S_WAIT: if (dev_ack) begin
          st_q    <= S_IDLE;
          dev_req <= 1'b0;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o     = (st_q == S_WAIT);
  assign done_o     = (st_q == S_WAIT) && dev_ack;
  assign done_dir_o = dev_dir;
  assign rx_o       = dev_rdata;
  assign perr_o     = !dev_dir && ((^dev_rdata) != dev_rpar);

  p_req_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (dev_req && !dev_ack) |=> dev_req);
  p_req_drop_r11: assert property (@(posedge clk) disable iff (rst)
    (dev_req && dev_ack) |=> !dev_req);
  p_start_when_idle_r6: assert property (@(posedge clk) disable iff (rst)
    start_i |-> !busy_o);
  p_req_after_start_r3: assert property (@(posedge clk) disable iff (rst)
    start_i |=> (dev_req && busy_o));
endmodule

// File: rtl/mmio_regs.sv
module mmio_regs
  import mmio_pkg::*;
#(
  parameter int BW = 32,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          acc_i,
  input  logic          we_i,
  input  sel_e          reg_i,
  input  logic [BW-1:0] wdata_i,
  input  logic          busy_i,
  input  logic          done_i,
  input  logic          done_dir_i,
  input  logic [DW-1:0] rx_i,
  input  logic          perr_i,
  output logic          start_o,
  output logic          start_dir_o,
  output logic [DW-1:0] tx_o,
  output logic [BW-1:0] rdata_o,
  output logic          irq_o,
  output logic          act_stb_o,
  output logic [3:0]    act_code_o
);
  logic          ready_q, ready_d, err_q, err_d, ovr_q, ovr_d, ie_q, ie_d;
  logic [1:0]    cmd_q, cmd_d;
  logic [3:0]    act_q, act_d;
  logic [DW-1:0] rx_q, rx_d, tx_q, tx_d;
  logic          stb_d;
  logic          wr_stat, wr_data, wr_ctrl, rd_data, is_xfer;
  logic [BW-1:0] rmux;
  logic          unused_wdata;

  assign unused_wdata = ^wdata_i[BW-1:8];
  assign wr_stat = acc_i && we_i && (reg_i == SEL_STAT);
  assign wr_data = acc_i && we_i && (reg_i == SEL_DATA);
  assign wr_ctrl = acc_i && we_i && (reg_i == SEL_CTRL);
  assign rd_data = acc_i && !we_i && (reg_i == SEL_DATA);
  assign is_xfer = wdata_i[1];

  always_comb begin
    ready_d     = ready_q;
    err_d       = err_q;
    ovr_d       = ovr_q;
    ie_d        = ie_q;
    cmd_d       = cmd_q;
    act_d       = act_q;
    rx_d        = rx_q;
    tx_d        = tx_q;
    stb_d       = 1'b0;
    start_o     = 1'b0;
    start_dir_o = wdata_i[0];
    if (wr_stat) begin
      if (wdata_i[ST_ERR]) err_d = 1'b0;
      if (wdata_i[ST_OVR]) ovr_d = 1'b0;
    end
    if (wr_data) tx_d = wdata_i[DW-1:0];
    if (rd_data) ready_d = 1'b0;
    if (wr_ctrl) begin
      if (is_xfer && busy_i) begin
        ovr_d = 1'b1;
      end else begin
        cmd_d = wdata_i[1:0];
        ie_d  = wdata_i[CW_IE];
        act_d = wdata_i[CW_ACT_LSB +: 4];
        if (is_xfer) begin
          start_o = 1'b1;
          ready_d = 1'b0;
        end else if (cmd_e'(wdata_i[1:0]) == CMD_ACTION) begin
          stb_d = 1'b1;
        end
      end
    end
    if (done_i) begin
      ready_d = 1'b1;
      if (!done_dir_i) begin
        rx_d = rx_i;
        if (perr_i) err_d = 1'b1;
      end
    end
  end

  always_comb begin
    rmux = '0;
    unique case (reg_i)
      SEL_STAT: begin
        rmux[ST_BUSY]  = busy_i;
        rmux[ST_READY] = ready_q;
        rmux[ST_ERR]   = err_q;
        rmux[ST_OVR]   = ovr_q;
      end
      SEL_DATA: rmux[DW-1:0] = rx_q;
      SEL_CTRL: begin
        rmux[1:0]              = cmd_q;
        rmux[CW_IE]            = ie_q;
        rmux[CW_ACT_LSB +: 4]  = act_q;
      end
      default: rmux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ready_q   <= 1'b0;
      err_q     <= 1'b0;
      ovr_q     <= 1'b0;
      ie_q      <= 1'b0;
      cmd_q     <= 2'b00;
      act_q     <= 4'h0;
      rx_q      <= '0;
      tx_q      <= '0;
      irq_o     <= 1'b0;
      act_stb_o <= 1'b0;
      rdata_o   <= '0;
    end else begin
      ready_q   <= ready_d;
      err_q     <= err_d;
      ovr_q     <= ovr_d;
      ie_q      <= ie_d;
      cmd_q     <= cmd_d;
      act_q     <= act_d;
      rx_q      <= rx_d;
      tx_q      <= tx_d;
      irq_o     <= ready_d && ie_d;
      act_stb_o <= stb_d;
      rdata_o   <= (acc_i && !we_i) ? rmux : '0;
    end
  end

  assign tx_o       = tx_q;
  assign act_code_o = act_q;

  p_irq_clear_r8: assert property (@(posedge clk) disable iff (rst)
    (rd_data && !done_i) |=> !irq_o);
  p_overrun_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    (ovr_q && !(wr_stat && wdata_i[ST_OVR])) |=> ovr_q);
  p_stb_single_r5: assert property (@(posedge clk) disable iff (rst)
    act_stb_o |=> !act_stb_o);
endmodule

// File: rtl/mmio_io_unit.sv
module mmio_io_unit #(
  parameter int          AW        = 32,
  parameter int          BW        = 32,
  parameter int          DW        = 8,
  parameter int          WIN_BITS  = 28,
  parameter logic [31:0] BASE_ADDR = 32'hF000_0000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_sel,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [BW-1:0] bus_wdata,
  output logic [BW-1:0] bus_rdata,
  output logic          bus_hit,
  output logic          irq,
  output logic          dev_req,
  output logic          dev_dir,
  output logic [DW-1:0] dev_wdata,
  output logic          dev_wpar,
  input  logic          dev_ack,
  input  logic [DW-1:0] dev_rdata,
  input  logic          dev_rpar,
  output logic          dev_act_stb,
  output logic [3:0]    dev_act_code
);
  import mmio_pkg::*;

  sel_e          reg_sel;
  logic          busy, done, done_dir, perr, start, start_dir;
  logic [DW-1:0] rx, tx;

  mmio_decode #(.AW(AW), .WIN_BITS(WIN_BITS), .BASE(AW'(BASE_ADDR))) u_dec (
    .clk(clk), .rst(rst), .sel_i(bus_sel), .addr_i(bus_addr),
    .reg_o(reg_sel), .hit_o(bus_hit)
  );

  mmio_regs #(.BW(BW), .DW(DW)) u_regs (
    .clk(clk), .rst(rst), .acc_i(bus_sel), .we_i(bus_we), .reg_i(reg_sel),
    .wdata_i(bus_wdata), .busy_i(busy), .done_i(done), .done_dir_i(done_dir),
    .rx_i(rx), .perr_i(perr), .start_o(start), .start_dir_o(start_dir),
    .tx_o(tx), .rdata_o(bus_rdata), .irq_o(irq), .act_stb_o(dev_act_stb),
    .act_code_o(dev_act_code)
  );

  mmio_dev_fsm #(.DW(DW)) u_fsm (
    .clk(clk), .rst(rst), .start_i(start), .start_dir_i(start_dir), .tx_i(tx),
    .busy_o(busy), .done_o(done), .done_dir_o(done_dir), .rx_o(rx),
    .perr_o(perr), .dev_req(dev_req), .dev_dir(dev_dir),
    .dev_wdata(dev_wdata), .dev_wpar(dev_wpar), .dev_ack(dev_ack),
    .dev_rdata(dev_rdata), .dev_rpar(dev_rpar)
  );
endmodule

// File: tb/mmio_io_unit_tb.sv
module mmio_io_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        bus_sel, bus_we;
  logic [31:0] bus_addr, bus_wdata, bus_rdata;
  logic        bus_hit, irq, dev_req, dev_dir, dev_wpar, dev_ack, dev_rpar, dev_act_stb;
  logic [7:0]  dev_wdata, dev_rdata;
  logic [3:0]  dev_act_code;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;
  logic [31:0] rd;

  localparam logic [31:0] A_STAT = 32'hF000_0000;
  localparam logic [31:0] A_DATA = 32'hF000_0004;
  localparam logic [31:0] A_CTRL = 32'hF000_0008;

  always #5 clk = ~clk;

  mmio_io_unit dut_i (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_hit(bus_hit), .irq(irq),
    .dev_req(dev_req), .dev_dir(dev_dir), .dev_wdata(dev_wdata), .dev_wpar(dev_wpar),
    .dev_ack(dev_ack), .dev_rdata(dev_rdata), .dev_rpar(dev_rpar),
    .dev_act_stb(dev_act_stb), .dev_act_code(dev_act_code)
  );

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 20000) begin
      n_fail++;
      $display("FAIL watchdog: act=%0d cycles exp<20000", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(logic [31:0] a, logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_rd(logic [31:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  task automatic ack_after(int wait_cyc, logic [7:0] d, logic p);
    repeat (wait_cyc) @(negedge clk);
    dev_ack = 1'b1; dev_rdata = d; dev_rpar = p;
    @(negedge clk);
    dev_ack = 1'b0;
  endtask

  task automatic t_reset();
    chk("R10 irq", {31'd0, irq}, 32'd0);
    chk("R10 dev_req", {31'd0, dev_req}, 32'd0);
    chk("R10 act_stb", {31'd0, dev_act_stb}, 32'd0);
    bus_rd(A_STAT, rd); chk("R10 status", rd, 32'h0);
    bus_rd(A_CTRL, rd); chk("R10 ctrl", rd, 32'h0);
  endtask

  task automatic t_fetch_ok();
    bus_wr(A_CTRL, 32'h6);
    chk("R3 req up", {31'd0, dev_req}, 32'd1);
    chk("R3 dir fetch", {31'd0, dev_dir}, 32'd0);
    bus_rd(A_STAT, rd); chk("R2 busy", rd, 32'h1);
    chk("R2 hit", {31'd0, bus_hit}, 32'd1);
    bus_rd(A_STAT, rd); chk("R2 no side effect", rd, 32'h1);
    chk("R11 req held", {31'd0, dev_req}, 32'd1);
    bus_wr(A_CTRL, 32'h7);
    chk("R6 req unchanged", {30'd0, dev_req, dev_dir}, 32'h2);
    bus_rd(A_STAT, rd); chk("R6 overrun set", rd, 32'h9);
    bus_rd(A_CTRL, rd); chk("R6 ctrl unchanged", rd, 32'h6);
    ack_after(3, 8'hA5, 1'b0);
    chk("R11 req dropped", {31'd0, dev_req}, 32'd0);
    chk("R8 irq up", {31'd0, irq}, 32'd1);
    bus_rd(A_STAT, rd); chk("R8 ready", rd, 32'hA);
    bus_rd(A_DATA, rd); chk("R3 data", rd, 32'hA5);
    chk("R8 irq cleared", {31'd0, irq}, 32'd0);
    bus_rd(A_STAT, rd); chk("R6 overrun sticky", rd, 32'h8);
    bus_wr(A_STAT, 32'h8);
    bus_rd(A_STAT, rd); chk("R6 overrun cleared", rd, 32'h0);
  endtask

  task automatic t_parity_err();
    bus_wr(A_CTRL, 32'h2);
    ack_after(2, 8'h3C, 1'b1);
    chk("R8 no irq when disabled", {31'd0, irq}, 32'd0);
    bus_rd(A_STAT, rd); chk("R7 error set", rd, 32'h6);
    bus_wr(A_STAT, 32'h0);
    bus_rd(A_STAT, rd); chk("R7 write 0 keeps", rd, 32'h6);
    bus_wr(A_STAT, 32'h4);
    bus_rd(A_STAT, rd); chk("R7 error cleared", rd, 32'h2);
    bus_rd(A_DATA, rd); chk("R3 data bad par", rd, 32'h3C);
    bus_wr(A_CTRL, 32'h2);
    ack_after(1, 8'h07, 1'b1);
    bus_rd(A_STAT, rd); chk("R7 good parity", rd, 32'h2);
    bus_rd(A_DATA, rd); chk("R3 data 07", rd, 32'h07);
  endtask

  task automatic t_send();
    bus_wr(A_DATA, 32'h07);
    bus_wr(A_CTRL, 32'h7);
    chk("R4 dir send", {31'd0, dev_dir}, 32'd1);
    chk("R4 wdata", {24'd0, dev_wdata}, 32'h07);
    chk("R4 parity", {31'd0, dev_wpar}, 32'd1);
    ack_after(4, 8'hFF, 1'b1);
    chk("R8 irq send", {31'd0, irq}, 32'd1);
    bus_rd(A_STAT, rd); chk("R8 ready send", rd, 32'h2);
    bus_rd(A_DATA, rd); chk("R3 rx kept after send", rd, 32'h07);
    chk("R8 irq clr send", {31'd0, irq}, 32'd0);
    bus_wr(A_DATA, 32'h81);
    bus_wr(A_CTRL, 32'h3);
    chk("R4 wdata 81", {23'd0, dev_wpar, dev_wdata}, 32'h081);
    ack_after(0, 8'h00, 1'b0);
    bus_rd(A_DATA, rd);
  endtask

  task automatic t_action();
    bus_wr(A_CTRL, 32'h94);
    chk("R5 strobe", {27'd0, dev_act_stb, dev_act_code}, 32'h19);
    chk("R5 no req", {31'd0, dev_req}, 32'd0);
    @(negedge clk);
    chk("R5 strobe one cycle", {31'd0, dev_act_stb}, 32'd0);
    bus_rd(A_CTRL, rd); chk("R5 ctrl readback", rd, 32'h94);
    bus_wr(A_CTRL, 32'h51);
    chk("R5 probe no strobe", {31'd0, dev_act_stb}, 32'd0);
    bus_rd(A_CTRL, rd); chk("R5 probe readback", rd, 32'h51);
  endtask

  task automatic t_window();
    bus_wr(32'hE000_0008, 32'h2);
    chk("R1 outside no hit", {31'd0, bus_hit}, 32'd0);
    chk("R1 outside no req", {31'd0, dev_req}, 32'd0);
    bus_rd(32'hE000_0000, rd);
    chk("R1 outside rdata", rd, 32'h0);
    chk("R1 outside hit", {31'd0, bus_hit}, 32'd0);
    bus_wr(32'hF000_000C, 32'hFF);
    bus_wr(32'hF123_0008, 32'h2);
    chk("R9 undefined no req", {31'd0, dev_req}, 32'd0);
    bus_rd(32'hF000_000C, rd);
    chk("R9 undefined rdata", rd, 32'h0);
    chk("R1 inside hit", {31'd0, bus_hit}, 32'd1);
    bus_rd(A_CTRL, rd); chk("R9 ctrl unchanged", rd, 32'h51);
  endtask

  initial begin
    rst = 1'b1; bus_sel = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    dev_ack = 1'b0; dev_rdata = '0; dev_rpar = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_fetch_ok();
    t_parity_err();
    t_send();
    t_action();
    t_window();
    summary();
    $finish;
  end
endmodule